// File: doc/BRIEF.md
# Serial DAC Host Write Controller

This block is the host-side master for one serial DAC, or for a chain of them. It takes one command over a valid/ready handshake. The command carries a mode, a frame count, a load request and a packed data vector. The block then drives a serial clock, MSB-first data, an active-low frame sync, an active-low load strobe and an active-low readback enable. Every interval on those lines is a fixed number of system-clock cycles. Each count comes from a nanosecond minimum and the system clock period, rounded up.

There are three kinds of transfer:

- **Standalone write:** one 16-bit frame at the fast clock rate.
- **Chained write:** several 16-bit frames under a single sync-low window, at the slow rate. The word for the device farthest down the chain goes out first.
- **Readback:** one frame at the slow rate with the readback enable held low. The returned serial stream is captured into a 16-bit word.

An optional load pulse can follow the frame. The block stays busy until the last gap after the frame has been honoured, so the next command can start at once.

Top module: `sdac_host_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the outputs are idle: sync, sclk, load strobe and readback enable are high, sdin is 0, cmd_ready_o is 1, busy_o is 0 and rd_valid_o is 0.
- R2: A command is taken when cmd_valid_i and cmd_ready_o are both high. In the next cycle sync is low, busy_o is high and cmd_ready_o is low. cmd_valid_i is ignored while busy: it changes neither the frame in progress nor the idle period that follows.
- R3: sclk idles high. Data is sent MSB first and is sampled at falling sclk edges. sdin changes only at a rising sclk edge or at the sync-fall edge, so it is stable across every falling edge.
- R4: Modes 0 and 3 use the fast rate: every sclk low phase and every high phase between bits lasts exactly HALF_FAST cycles (18 at defaults). Modes 1 and 2 use the slow rate, HALF_SLOW cycles (63 at defaults).
- R5: The first falling sclk edge comes exactly LEAD cycles after sync falls (13 at defaults).
- R6: Mode 1 (chain) with frame field f sends f+1 frames, which is 16×(f+1) falling edges under one sync-low window. Slot f (cmd_data_i[16f+15:16f]) goes first and slot 0 goes last, so the serial stream equals cmd_data_i[16(f+1)-1:0] sent MSB first.
- R7: Mode 2 (readback) holds the readback enable low for exactly the sync-low window. sdo_i is sampled at every rising sclk edge, which gives 16 bits MSB first in rd_data_o. rd_valid_o pulses for one cycle in the cycle sync rises.
- R8: When cmd_load_i was set, the load strobe falls exactly 13 cycles after sync rises and stays low exactly 13 cycles (defaults). Without it, the load strobe stays high.
- R9: Sync stays high for at least 13 cycles between frames, and falls at least 2 cycles after the load strobe rises. busy_o falls exactly 13 cycles after sync rises without a load, and exactly 28 cycles after with a load (defaults).
- R10: Modes 0, 2 and 3 send exactly one frame, cmd_data_i[15:0], whatever the frame field holds. Mode 3 behaves exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle, command taken this cycle if offered |
| cmd_mode_i | input | 2 | 0 standalone, 1 chain, 2 readback, 3 as standalone |
| cmd_frames_i | input | FRM_W | Chain frame count minus one |
| cmd_load_i | input | 1 | Issue a load pulse after the frame |
| cmd_data_i | input | 16·2^FRM_W | Packed words, slot 0 nearest device |
| busy_o | output | 1 | Transfer or trailing gap in progress |
| sclk_o | output | 1 | Serial clock, idles high |
| sdin_o | output | 1 | Serial data to the devices |
| sync_no | output | 1 | Frame sync, active low |
| ldac_no | output | 1 | Load strobe, active low |
| rben_no | output | 1 | Readback enable, active low |
| sdo_i | input | 1 | Serial data returned from the devices |
| rd_data_o | output | 16 | Captured readback word |
| rd_valid_o | output | 1 | One-cycle pulse when rd_data_o is new |

## Verification
The bench measures every sclk phase and checks it against the rate of the current mode. A design that kept the fast rate in chain or readback mode would overclock the devices and fail the phase check.

A chain of four frames checks both the farthest-first order and that sync stays low across frame boundaries. A block that raised sync between frames, or reversed the slots, would scramble the serial stream the bench captures.

Readback checks the capture edge and the bit order against a device model that launches bits on falling edges.

The gap after the frame is counted both with and without a load pulse. A block that dropped busy early, or that ran the load pulse before the sync-to-load gap, would show a wrong busy length or a wrong strobe position.

Commands offered while busy must start nothing.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [1:0] {
    MODE_SOLO  = 2'd0,
    MODE_CHAIN = 2'd1,
    MODE_READ  = 2'd2,
    MODE_ALT   = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_SETTLE,
    ST_PULSE,
    ST_TAIL
  } state_e;

  function automatic int unsigned cdiv(int unsigned num, int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdac_timer.sv
module sdac_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  assert_len_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (len_i != '0));

endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int WORD_W  = 16,
  parameter int MAX_DEV = 4,
  parameter int FRM_W   = 2,
  localparam int TX_W   = WORD_W * MAX_DEV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TX_W-1:0]   data_i,
  input  logic [FRM_W-1:0]  frames_i,
  input  logic              shift_i,
  input  logic              capture_i,
  input  logic              sdo_i,
  output logic              sdin_o,
  output logic [WORD_W-1:0] rx_o
);

  logic [TX_W-1:0]   tx_q;
  logic [WORD_W-1:0] rx_q;
  int unsigned       pad;

  // unused upper slots are pushed out so the farthest used slot leads
  always_comb pad = WORD_W * (MAX_DEV - 1 - int'(frames_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tx_q <= '0;
    else if (load_i)   tx_q <= data_i << pad;
    else if (shift_i)  tx_q <= {tx_q[TX_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rx_q <= '0;
    else if (capture_i)  rx_q <= {rx_q[WORD_W-2:0], sdo_i};
  end

  assign sdin_o = tx_q[TX_W-1];
  assign rx_o   = rx_q;

endmodule

// File: rtl/sdac_seq.sv
module sdac_seq
  import sdac_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int MAX_DEV     = 4,
  parameter int FRM_W       = 2,
  parameter int CNT_W       = 8,
  parameter int HALF_FAST   = 18,
  parameter int HALF_SLOW   = 63,
  parameter int LEAD_CYC    = 13,
  parameter int SYNC_HI_CYC = 13,
  parameter int TO_LOAD_CYC = 13,
  parameter int LOAD_CYC    = 13,
  parameter int TAIL_CYC    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_mode_i,
  input  logic [FRM_W-1:0] cmd_frames_i,
  input  logic             cmd_load_i,
  output logic             cmd_ready_o,
  output logic             busy_o,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_len_o,
  output logic             tx_load_o,
  output logic [FRM_W-1:0] frames_o,
  output logic             tx_shift_o,
  output logic             rx_cap_o,
  output logic             sclk_o,
  output logic             sync_no,
  output logic             ldac_no,
  output logic             rben_no,
  output logic             rd_valid_o
);

  localparam int BIT_W = $clog2(WORD_W * MAX_DEV);

  state_e           state_q, state_d;
  logic             slow_q, slow_d, read_q, read_d, load_q, load_d;
  logic [BIT_W-1:0] last_q, last_d, bit_q, bit_d;
  logic             sclk_q, sclk_d, sync_q, sync_d, ldac_q, ldac_d;
  logic             rben_q, rben_d, rdv_q, rdv_d;
  logic [CNT_W-1:0] half;
  mode_e            mode;

  assign mode     = mode_e'(cmd_mode_i);
  assign half     = slow_q ? CNT_W'(HALF_SLOW) : CNT_W'(HALF_FAST);
  assign frames_o = (mode == MODE_CHAIN) ? cmd_frames_i : '0;

  always_comb begin
    state_d    = state_q;
    slow_d     = slow_q;
    read_d     = read_q;
    load_d     = load_q;
    last_d     = last_q;
    bit_d      = bit_q;
    sclk_d     = sclk_q;
    sync_d     = sync_q;
    ldac_d     = ldac_q;
    rben_d     = rben_q;
    rdv_d      = 1'b0;
    tmr_load_o = 1'b0;
    tmr_len_o  = '0;
    tx_load_o  = 1'b0;
    tx_shift_o = 1'b0;
    rx_cap_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cmd_valid_i) begin
        state_d    = ST_LEAD;
        tmr_load_o = 1'b1;
        tmr_len_o  = CNT_W'(LEAD_CYC);
        tx_load_o  = 1'b1;
        sync_d     = 1'b0;
        slow_d     = (mode == MODE_CHAIN) || (mode == MODE_READ);
        read_d     = (mode == MODE_READ);
        rben_d     = (mode != MODE_READ);
        load_d     = cmd_load_i;
        bit_d      = '0;
        last_d     = BIT_W'((int'(frames_o) + 1) * WORD_W - 1);
      end
      ST_LEAD: if (tmr_done_i) begin
        state_d    = ST_LOW;
        sclk_d     = 1'b0;
        tmr_load_o = 1'b1;
        tmr_len_o  = half;
      end
      ST_LOW: if (tmr_done_i) begin
        sclk_d     = 1'b1;
        tx_shift_o = 1'b1;
        rx_cap_o   = read_q;
        tmr_load_o = 1'b1;
        if (bit_q == last_q) begin
          state_d   = ST_SETTLE;
          sync_d    = 1'b1;
          rben_d    = 1'b1;
          rdv_d     = read_q;
          tmr_len_o = load_q ? CNT_W'(TO_LOAD_CYC) : CNT_W'(SYNC_HI_CYC);
        end else begin
          state_d   = ST_HIGH;
          bit_d     = bit_q + 1'b1;
          tmr_len_o = half;
        end
      end
      ST_HIGH: if (tmr_done_i) begin
        state_d    = ST_LOW;
        sclk_d     = 1'b0;
        tmr_load_o = 1'b1;
        tmr_len_o  = half;
      end
      ST_SETTLE: if (tmr_done_i) begin
        if (load_q) begin
          state_d    = ST_PULSE;
          ldac_d     = 1'b0;
          tmr_load_o = 1'b1;
          tmr_len_o  = CNT_W'(LOAD_CYC);
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_PULSE: if (tmr_done_i) begin
        state_d    = ST_TAIL;
        ldac_d     = 1'b1;
        tmr_load_o = 1'b1;
        tmr_len_o  = CNT_W'(TAIL_CYC);
      end
      ST_TAIL: if (tmr_done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slow_q  <= 1'b0;
      read_q  <= 1'b0;
      load_q  <= 1'b0;
      last_q  <= '0;
      bit_q   <= '0;
      sclk_q  <= 1'b1;
      sync_q  <= 1'b1;
      ldac_q  <= 1'b1;
      rben_q  <= 1'b1;
      rdv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      slow_q  <= slow_d;
      read_q  <= read_d;
      load_q  <= load_d;
      last_q  <= last_d;
      bit_q   <= bit_d;
      sclk_q  <= sclk_d;
      sync_q  <= sync_d;
      ldac_q  <= ldac_d;
      rben_q  <= rben_d;
      rdv_q   <= rdv_d;
    end
  end

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);
  assign sclk_o      = sclk_q;
  assign sync_no     = sync_q;
  assign ldac_no     = ldac_q;
  assign rben_no     = rben_q;
  assign rd_valid_o  = rdv_q;

  assert_accept_starts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> (!sync_no && busy_o));

  assert_load_outside_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ldac_no |-> sync_no);

  assert_rben_framed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rben_no |-> !sync_no);

  assert_rd_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $rose(sync_no));

endmodule

// File: rtl/sdac_host_ctrl.sv
module sdac_host_ctrl
  import sdac_pkg::*;
#(
  parameter int SYS_PERIOD_PS   = 4000,
  parameter int FRM_W           = 2,
  parameter int WORD_W          = 16,
  parameter int FAST_PERIOD_NS  = 143,
  parameter int FAST_PHASE_NS   = 60,
  parameter int SLOW_PERIOD_NS  = 500,
  parameter int SLOW_PHASE_NS   = 200,
  parameter int DATA_SETUP_NS   = 15,
  parameter int SYNC_LEAD_NS    = 50,
  parameter int SYNC_HIGH_NS    = 50,
  parameter int SYNC_TO_LOAD_NS = 50,
  parameter int LOAD_WIDTH_NS   = 50,
  parameter int LOAD_TO_SYNC_NS = 5
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              cmd_valid_i,
  output logic                              cmd_ready_o,
  input  logic [1:0]                        cmd_mode_i,
  input  logic [FRM_W-1:0]                  cmd_frames_i,
  input  logic                              cmd_load_i,
  input  logic [WORD_W*(1<<FRM_W)-1:0]      cmd_data_i,
  output logic                              busy_o,
  output logic                              sclk_o,
  output logic                              sdin_o,
  output logic                              sync_no,
  output logic                              ldac_no,
  output logic                              rben_no,
  input  logic                              sdo_i,
  output logic [WORD_W-1:0]                 rd_data_o,
  output logic                              rd_valid_o
);

  localparam int MAX_DEV = 1 << FRM_W;
  localparam int unsigned PS = SYS_PERIOD_PS;
  localparam int unsigned DSU_C = cdiv(DATA_SETUP_NS * 1000, PS);
  localparam int unsigned HALF_FAST = umax(umax(cdiv(FAST_PERIOD_NS * 1000, 2 * PS),
                                                cdiv(FAST_PHASE_NS * 1000, PS)), umax(DSU_C, 1));
  localparam int unsigned HALF_SLOW = umax(umax(cdiv(SLOW_PERIOD_NS * 1000, 2 * PS),
                                                cdiv(SLOW_PHASE_NS * 1000, PS)), umax(DSU_C, 1));
  localparam int unsigned LEAD_C    = umax(umax(cdiv(SYNC_LEAD_NS * 1000, PS), DSU_C), 1);
  localparam int unsigned SYH_C     = umax(cdiv(SYNC_HIGH_NS * 1000, PS), 1);
  localparam int unsigned TOL_C     = umax(cdiv(SYNC_TO_LOAD_NS * 1000, PS), 1);
  localparam int unsigned LW_C      = umax(cdiv(LOAD_WIDTH_NS * 1000, PS), 1);
  localparam int unsigned COVER_C   = TOL_C + LW_C;
  // tail also tops up the sync-high minimum when the pulse is short
  localparam int unsigned TAIL_C    = umax(umax(cdiv(LOAD_TO_SYNC_NS * 1000, PS),
                                                (SYH_C > COVER_C) ? SYH_C - COVER_C : 0), 1);
  localparam int unsigned MAX_C     = umax(umax(umax(HALF_FAST, HALF_SLOW), umax(LEAD_C, SYH_C)),
                                           umax(umax(TOL_C, LW_C), TAIL_C));
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic             tmr_load, tmr_done, tx_load, tx_shift, rx_cap;
  logic [CNT_W-1:0] tmr_len;
  logic [FRM_W-1:0] frames_eff;

  sdac_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .done_o (tmr_done)
  );

  sdac_shift #(.WORD_W(WORD_W), .MAX_DEV(MAX_DEV), .FRM_W(FRM_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tx_load),
    .data_i    (cmd_data_i),
    .frames_i  (frames_eff),
    .shift_i   (tx_shift),
    .capture_i (rx_cap),
    .sdo_i     (sdo_i),
    .sdin_o    (sdin_o),
    .rx_o      (rd_data_o)
  );

  sdac_seq #(
    .WORD_W(WORD_W), .MAX_DEV(MAX_DEV), .FRM_W(FRM_W), .CNT_W(CNT_W),
    .HALF_FAST(int'(HALF_FAST)), .HALF_SLOW(int'(HALF_SLOW)), .LEAD_CYC(int'(LEAD_C)),
    .SYNC_HI_CYC(int'(SYH_C)), .TO_LOAD_CYC(int'(TOL_C)), .LOAD_CYC(int'(LW_C)),
    .TAIL_CYC(int'(TAIL_C))
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_mode_i   (cmd_mode_i),
    .cmd_frames_i (cmd_frames_i),
    .cmd_load_i   (cmd_load_i),
    .cmd_ready_o  (cmd_ready_o),
    .busy_o       (busy_o),
    .tmr_done_i   (tmr_done),
    .tmr_load_o   (tmr_load),
    .tmr_len_o    (tmr_len),
    .tx_load_o    (tx_load),
    .frames_o     (frames_eff),
    .tx_shift_o   (tx_shift),
    .rx_cap_o     (rx_cap),
    .sclk_o       (sclk_o),
    .sync_no      (sync_no),
    .ldac_no      (ldac_no),
    .rben_no      (rben_no),
    .rd_valid_o   (rd_valid_o)
  );

  assert_idle_clock_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_no |-> sclk_o);

  assert_sdin_steady_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclk_o && !$past(sclk_o)) |-> $stable(sdin_o));

  assert_sdin_steady_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> $stable(sdin_o));

endmodule

// File: tb/sdac_host_ctrl_bench.sv
module sdac_host_ctrl_bench;

  localparam int HF = 18, HS = 63, LEAD = 13, SYH = 13, TOL = 13, LW = 13, TAIL = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_load = 1'b0, sdo_r = 1'b0;
  logic [1:0]  cmd_mode = '0, cmd_frames = '0;
  logic [63:0] cmd_data = '0;
  logic        cmd_ready, busy, sclk, sdin, sync_n, ldac_n, rben_n, rd_valid;
  logic [15:0] rd_data;

  always #2 clk = ~clk;

  sdac_host_ctrl u_sdac_host_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_mode_i(cmd_mode), .cmd_frames_i(cmd_frames), .cmd_load_i(cmd_load),
    .cmd_data_i(cmd_data), .busy_o(busy), .sclk_o(sclk), .sdin_o(sdin),
    .sync_no(sync_n), .ldac_no(ldac_n), .rben_no(rben_n), .sdo_i(sdo_r),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expectations set by the driver one idle cycle before a command
  int          exp_half, exp_nfall;
  logic [63:0] exp_bits;
  bit          exp_read, exp_load;
  logic [15:0] exp_rb;
  string       exp_tag;

  // monitor state
  bit          p_sync = 1, p_sclk = 1, p_ldac = 1, p_busy = 0, seen_frame = 0, ldac_seen = 0;
  int          run, nfall, ridx, sync_hi, rise_cnt, lrun, aft, busy_cnt;
  int          lead_act, ph_bad, ph_act, ph_exp;
  logic [63:0] cap;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_sync && !sync_n) begin
        check(rben_n == !exp_read, "R7", "readback enable at frame start", rben_n, !exp_read);
        if (seen_frame) check(sync_hi >= SYH, "R9", "sync high gap", sync_hi, SYH);
        if (ldac_seen) check(aft >= TAIL, "R9", "load rise to sync fall", aft, TAIL);
        nfall = 0; cap = '0; run = 1; ridx = 0; seen_frame = 1; ldac_seen = 0;
        ph_bad = 0; lead_act = -1;
      end else if (!sync_n) begin
        if (sclk != p_sclk) begin
          if (!sclk) begin
            if (nfall == 0) lead_act = run;
            else if (run != exp_half && ph_bad == 0) begin ph_bad = 1; ph_act = run; ph_exp = exp_half; end
            cap = {cap[62:0], sdin};
            nfall++;
            if (!rben_n) begin sdo_r = exp_rb[15-ridx]; ridx++; end
          end else if (run != exp_half && ph_bad == 0) begin
            ph_bad = 1; ph_act = run; ph_exp = exp_half;
          end
          run = 1;
        end else run++;
      end else if (!p_sync && sync_n) begin
        check(lead_act == LEAD, "R5", "sync fall to first sclk fall", lead_act, LEAD);
        check(ph_bad == 0, "R4", "sclk phase length", ph_act, ph_exp);
        check(nfall == exp_nfall, exp_tag, "falling edges in sync window", nfall, exp_nfall);
        check(cap == exp_bits, exp_tag, "serial stream", cap, exp_bits);
        check(rd_valid == exp_read, "R7", "rd_valid at sync rise", rd_valid, exp_read);
        if (exp_read) check(rd_data == exp_rb, "R7", "readback word", rd_data, exp_rb);
        sync_hi = 1; rise_cnt = 1; busy_cnt = 1;
      end else begin
        if (p_ldac && !ldac_n) begin
          check(exp_load, "R8", "load strobe without request", 1, exp_load);
          check(rise_cnt == TOL, "R8", "sync rise to load fall", rise_cnt, TOL);
          lrun = 1;
        end else if (!p_ldac && ldac_n) begin
          check(lrun == LW, "R8", "load pulse width", lrun, LW);
          aft = 1; ldac_seen = 1;
        end else begin
          if (!ldac_n) lrun++;
          if (ldac_seen) aft++;
        end
        if (p_busy && !busy)
          check(busy_cnt == (exp_load ? TOL + LW + TAIL : SYH), "R9", "busy after sync rise",
                busy_cnt, exp_load ? TOL + LW + TAIL : SYH);
        else if (busy) busy_cnt++;
        rise_cnt++; sync_hi++;
      end
      p_sync = sync_n; p_sclk = sclk; p_ldac = ldac_n; p_busy = busy;
    end
  end

  task automatic run_cmd(input logic [1:0] mode, input logic [1:0] frm, input bit ld,
                         input logic [63:0] data, input logic [15:0] rb, input bit poke);
    int n;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    n         = (mode == 2'd1) ? int'(frm) + 1 : 1;
    exp_half  = (mode == 2'd1 || mode == 2'd2) ? HS : HF;
    exp_nfall = 16 * n;
    exp_bits  = (n == 4) ? data : (data & ((64'd1 << (16 * n)) - 64'd1));
    exp_read  = (mode == 2'd2);
    exp_load  = ld;
    exp_rb    = rb;
    exp_tag   = (mode == 2'd1) ? "R6" : ((mode == 2'd3 || frm != 0) ? "R10" : "R3");
    cmd_mode = mode; cmd_frames = frm; cmd_load = ld; cmd_data = data; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy && !sync_n && !cmd_ready, "R2", "state after accept",
          {busy, sync_n, cmd_ready}, 3'b100);
    if (poke) begin
      repeat (40) @(negedge clk);
      cmd_data = ~data; cmd_mode = 2'd0; cmd_valid = 1'b1;
      repeat (5) @(negedge clk);
      cmd_valid = 1'b0;
    end
    @(negedge clk);
    while (busy) @(negedge clk);
    if (poke) begin
      int falls = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!sync_n || busy) falls++;
      end
      check(falls == 0, "R2", "offer while busy started a transfer", falls, 0);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    check({sync_n, sclk, ldac_n, rben_n, sdin, cmd_ready, busy, rd_valid} == 8'b1111_0100,
          "R1", "outputs in reset", {sync_n, sclk, ldac_n, rben_n, sdin, cmd_ready, busy, rd_valid},
          8'b1111_0100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({sync_n, sclk, ldac_n, rben_n, sdin, cmd_ready, busy} == 7'b1111_010,
          "R1", "outputs after reset", {sync_n, sclk, ldac_n, rben_n, sdin, cmd_ready, busy},
          7'b1111_010);

    run_cmd(2'd0, 2'd0, 1'b0, 64'h0000_0000_0000_A5C3, 16'h0, 1'b0);   // R3 solo
    run_cmd(2'd0, 2'd0, 1'b1, 64'h0000_0000_0000_8001, 16'h0, 1'b0);   // R8 with load
    run_cmd(2'd1, 2'd3, 1'b1, 64'h1111_2222_3333_4444, 16'h0, 1'b0);   // R6 four frames
    run_cmd(2'd1, 2'd1, 1'b0, 64'hFFFF_FFFF_0F0F_F0F0, 16'h0, 1'b0);   // R6 two frames
    run_cmd(2'd2, 2'd0, 1'b0, 64'h0, 16'h2ACE, 1'b0);                   // R7 readback
    run_cmd(2'd3, 2'd2, 1'b0, 64'hDEAD_BEEF_CAFE_1234, 16'h0, 1'b0);   // R10 mode 3
    run_cmd(2'd0, 2'd3, 1'b0, 64'hDEAD_BEEF_CAFE_5678, 16'h0, 1'b0);   // R10 frames ignored
    run_cmd(2'd0, 2'd0, 1'b0, 64'h0000_0000_0000_3C3C, 16'h0, 1'b1);   // R2 offer while busy

    for (int k = 0; k < 10; k++) begin
      logic [1:0]  m, f;
      logic [63:0] d;
      m = 2'($urandom % 4);
      f = 2'($urandom % 4);
      d = {$urandom, $urandom};
      run_cmd(m, f, 1'($urandom % 2), d, 16'($urandom) & 16'h3FFF, 1'b0);
    end

    repeat (10) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule